// File: doc/BRIEF.md
# Read-Modify-Write Shift and Count Unit

This unit executes the single-operand modify operations of a small 8-bit processor core: shift left, shift right, rotate left through carry, rotate right through carry, increment and decrement. The operand comes from the accumulator, from one of the index registers, or from a byte in memory at a 16-bit address. The surrounding core supplies the current register values and the carry flag, and pulses a start request. The unit returns the new value, a register write strobe naming the target, and the new carry, zero and negative flags.

For a register target the result is ready one cycle after the start. For a memory target the unit runs its own bus sequence. It issues a one-cycle read strobe, waits a parameterised read latency, captures the returned byte and computes the new value. It then issues a one-cycle write strobe that puts the result back at the same address. A busy output covers the whole operation, and any request that arrives while busy is high is dropped.

Top module: `rmw_unit`

## Requirements
- R1: Target codes are 0 for the accumulator (`acc_i`), k for index register k (1..NUM_IDX, taken from `idx_i[(k-1)*DATA_W +: DATA_W]`) and NUM_IDX+1 for memory. For a register target the operand is sampled at the accepted start. In the next cycle `done_o` and `res_we_o` are high for exactly one cycle, with `res_tgt_o` equal to the target code.
- R2: Operation code 0 shifts left: carry out is the old MSB and the LSB fills with 0. Code 1 shifts right: carry out is the old LSB and the MSB fills with 0.
- R3: Code 2 rotates left: carry out is the old MSB and the LSB takes `carry_i`. Code 3 rotates right: carry out is the old LSB and the MSB takes `carry_i`.
- R4: Code 4 increments and code 5 decrements, both modulo 2^DATA_W (0x80 minus one is 0x7F, 0x00 minus one is 0xFF). For both, `carry_o` equals the `carry_i` sampled at start.
- R5: While `done_o` is high, `neg_o` equals the MSB of the result and `zero_o` is high exactly when the result is all zeros.
- R6: For a memory target, `mem_rd_o` is high for one cycle in the cycle after the start, with `mem_addr_o` equal to `addr_i`. `mem_rdata_i` is captured READ_LAT cycles after that strobe cycle. In the cycle after the capture, `mem_wr_o` and `done_o` are high for one cycle, with the same address and the transformed byte on `mem_wdata_o`.
- R7: `busy_o` is high from the cycle after an accepted start through the cycle with `done_o`, and low otherwise. A start while `busy_o` is high is ignored.
- R8: A start with operation code 6 or 7, or with a target code above NUM_IDX+1, is ignored: `busy_o` stays low and no strobe appears.
- R9: A memory-target operation never raises `res_we_o`, and a register-target operation never raises `mem_rd_o` or `mem_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one operation |
| op_i | input | 3 | Operation code (0..5) |
| tgt_i | input | TGT_W | Target code |
| addr_i | input | ADDR_W | Memory operand address |
| acc_i | input | DATA_W | Current accumulator value |
| idx_i | input | NUM_IDX*DATA_W | Current index register values, register 1 in the low bits |
| carry_i | input | 1 | Current carry flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result and flags valid this cycle |
| res_o | output | DATA_W | Result value |
| res_we_o | output | 1 | Write result to register `res_tgt_o` |
| res_tgt_o | output | TGT_W | Target code of the finishing operation |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | New zero flag |
| neg_o | output | 1 | New negative flag |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_rd_o | output | 1 | Bus read strobe |
| mem_rdata_i | input | DATA_W | Bus read data, READ_LAT cycles after the strobe |
| mem_wr_o | output | 1 | Bus write strobe |
| mem_wdata_o | output | DATA_W | Bus write data |

## Verification
The assertions assume that the memory returns read data exactly READ_LAT cycles after the read strobe. They also assume that register and carry inputs need only be valid in the cycle of an accepted start. The bench's memory model answers each read strobe with the stored byte one cycle later, which matches the default latency. It changes the register and carry inputs only at falling edges, together with the request. Requests are also raised in the middle of a memory sequence and with unused operation codes, so the rule that such requests are dropped is exercised inside these assumptions.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_ROTL = 3'd2,
      OP_ROTR = 3'd3,
      OP_INC  = 3'd4,
      OP_DEC  = 3'd5
   } rmw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_WRITE = 3'd3,
      ST_REG   = 3'd4
   } rmw_state_e;

   function automatic logic op_legal(input logic [2:0] code);
      return code <= 3'd5;
   endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu import rmw_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o,
   output logic              zero_o,
   output logic              neg_o
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("rmw_alu: DATA_W must be at least 2");
   end

   always_comb begin
      res_o  = val_i;
      cout_o = cin_i;
      case (op_i)
         OP_SHL: begin
            res_o  = {val_i[MSB-1:0], 1'b0};
            cout_o = val_i[MSB];
         end
         OP_SHR: begin
            res_o  = {1'b0, val_i[MSB:1]};
            cout_o = val_i[0];
         end
         OP_ROTL: begin
            res_o  = {val_i[MSB-1:0], cin_i};
            cout_o = val_i[MSB];
         end
         OP_ROTR: begin
            res_o  = {cin_i, val_i[MSB:1]};
            cout_o = val_i[0];
         end
         OP_INC: res_o = val_i + DATA_W'(1);
         OP_DEC: res_o = val_i - DATA_W'(1);
         default: begin
            res_o  = val_i;
            cout_o = cin_i;
         end
      endcase
   end

   assign zero_o = (res_o == '0);
   assign neg_o  = res_o[MSB];

endmodule

// File: rtl/rmw_operand_sel.sv
module rmw_operand_sel #(
   parameter int DATA_W  = 8,
   parameter int NUM_IDX = 2,
   localparam int TGT_W  = $clog2(NUM_IDX + 2)
) (
   input  logic [TGT_W-1:0]          tgt_i,
   input  logic [DATA_W-1:0]         acc_i,
   input  logic [NUM_IDX*DATA_W-1:0] idx_i,
   output logic [DATA_W-1:0]         val_o,
   output logic                      is_mem_o,
   output logic                      legal_o
);

   localparam int MEM_CODE = NUM_IDX + 1;

   if (NUM_IDX < 1) begin : g_bad_idx
      $error("rmw_operand_sel: NUM_IDX must be at least 1");
   end

   logic [DATA_W-1:0] regs [NUM_IDX+1];

   assign regs[0] = acc_i;
   for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx
      assign regs[k+1] = idx_i[k*DATA_W +: DATA_W];
   end

   always_comb begin
      val_o = '0;
      for (int k = 0; k <= NUM_IDX; k++) begin
         if (tgt_i == TGT_W'(k)) val_o = regs[k];
      end
   end

   assign is_mem_o = (tgt_i == TGT_W'(MEM_CODE));

   if ((1 << TGT_W) > MEM_CODE + 1) begin : g_sparse_codes
      assign legal_o = (tgt_i <= TGT_W'(MEM_CODE));
   end else begin : g_full_codes
      assign legal_o = 1'b1;
   end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq import rmw_pkg::*; #(
   parameter int READ_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic go_mem_i,
   output logic busy_o,
   output logic rd_o,
   output logic cap_o,
   output logic wr_o,
   output logic reg_done_o
);

   if (READ_LAT < 1) begin : g_bad_lat
      $error("rmw_seq: READ_LAT must be at least 1");
   end

   rmw_state_e st_q, st_d;
   logic       last_wait;

   if (READ_LAT == 1) begin : g_lat_one
      assign last_wait = 1'b1;
   end else begin : g_lat_multi
      localparam int CNT_W = $clog2(READ_LAT);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt_q <= '0;
         else if (st_q != ST_WAIT) cnt_q <= '0;
         else                      cnt_q <= cnt_q + CNT_W'(1);
      end
      assign last_wait = (cnt_q == CNT_W'(READ_LAT - 1));
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (go_i) st_d = go_mem_i ? ST_READ : ST_REG;
         ST_READ:  st_d = ST_WAIT;
         ST_WAIT:  if (last_wait) st_d = ST_WRITE;
         ST_WRITE: st_d = ST_IDLE;
         ST_REG:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign rd_o       = (st_q == ST_READ);
   assign cap_o      = (st_q == ST_WAIT) && last_wait;
   assign wr_o       = (st_q == ST_WRITE);
   assign reg_done_o = (st_q == ST_REG);

   // R6: each bus strobe lasts one cycle, and a write follows a capture
   p_rd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |=> !rd_o);
   p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> !wr_o);
   p_wr_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> $past(cap_o));
   p_rd_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |=> (busy_o && !wr_o));

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit import rmw_pkg::*; #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int NUM_IDX  = 2,
   parameter int READ_LAT = 1,
   localparam int TGT_W   = $clog2(NUM_IDX + 2)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [2:0]                op_i,
   input  logic [TGT_W-1:0]          tgt_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [DATA_W-1:0]         acc_i,
   input  logic [NUM_IDX*DATA_W-1:0] idx_i,
   input  logic                      carry_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [DATA_W-1:0]         res_o,
   output logic                      res_we_o,
   output logic [TGT_W-1:0]          res_tgt_o,
   output logic                      carry_o,
   output logic                      zero_o,
   output logic                      neg_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic                      mem_rd_o,
   input  logic [DATA_W-1:0]         mem_rdata_i,
   output logic                      mem_wr_o,
   output logic [DATA_W-1:0]         mem_wdata_o
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("rmw_unit: ADDR_W must be positive");
   end

   logic              tgt_ok, is_mem, accept;
   logic              cap, seq_rd, seq_wr, seq_reg_done;
   logic [DATA_W-1:0] reg_val, opnd_q, alu_res;
   logic [2:0]        op_q;
   logic [TGT_W-1:0]  tgt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cin_q, alu_c;

   rmw_operand_sel #(.DATA_W(DATA_W), .NUM_IDX(NUM_IDX)) u_sel (
      .tgt_i   (tgt_i),
      .acc_i   (acc_i),
      .idx_i   (idx_i),
      .val_o   (reg_val),
      .is_mem_o(is_mem),
      .legal_o (tgt_ok)
   );

   assign accept = start_i && !busy_o && op_legal(op_i) && tgt_ok;

   rmw_seq #(.READ_LAT(READ_LAT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (accept),
      .go_mem_i  (is_mem),
      .busy_o    (busy_o),
      .rd_o      (seq_rd),
      .cap_o     (cap),
      .wr_o      (seq_wr),
      .reg_done_o(seq_reg_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         tgt_q  <= '0;
         addr_q <= '0;
         cin_q  <= 1'b0;
         opnd_q <= '0;
      end else if (accept) begin
         op_q   <= op_i;
         tgt_q  <= tgt_i;
         addr_q <= addr_i;
         cin_q  <= carry_i;
         opnd_q <= reg_val;
      end else if (cap) begin
         opnd_q <= mem_rdata_i;
      end
   end

   rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .op_i  (op_q),
      .val_i (opnd_q),
      .cin_i (cin_q),
      .res_o (alu_res),
      .cout_o(alu_c),
      .zero_o(zero_o),
      .neg_o (neg_o)
   );

   assign res_o       = alu_res;
   assign carry_o     = alu_c;
   assign mem_wdata_o = alu_res;
   assign mem_addr_o  = addr_q;
   assign mem_rd_o    = seq_rd;
   assign mem_wr_o    = seq_wr;
   assign res_we_o    = seq_reg_done;
   assign res_tgt_o   = tgt_q;
   assign done_o      = seq_wr | seq_reg_done;

   // R4: counting operations hand the sampled carry back unchanged
   p_carry_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (op_q == OP_INC || op_q == OP_DEC)) |-> (carry_o == cin_q));
   // R5: a result cannot be both zero and negative
   p_nz_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(zero_o && neg_o));
   // R6: the bus address holds for the whole operation
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
   // R7: completion returns the unit to idle; idle means a quiet bus
   p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_rd_o && !mem_wr_o && !done_o));
   // R8: an unused operation code never starts a sequence
   p_bad_op_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !op_legal(op_i)) |=> !busy_o);
   // R9: register write-back and memory strobes exclude each other
   p_regwe_nomem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> (!mem_wr_o && !mem_rd_o));

endmodule

// File: tb/test_rmw_unit.sv
module test_rmw_unit;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int ADDR_W     = 16;
   localparam int NUM_IDX    = 2;
   localparam int TGT_W      = 2;
   localparam int MEM_TGT    = 3;
   localparam int WD_LIMIT   = 100000;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      start_i = 1'b0;
   logic [2:0]                op_i = '0;
   logic [TGT_W-1:0]          tgt_i = '0;
   logic [ADDR_W-1:0]         addr_i = '0;
   logic [DATA_W-1:0]         acc_i = '0;
   logic [NUM_IDX*DATA_W-1:0] idx_i = '0;
   logic                      carry_i = 1'b0;
   logic                      busy_o, done_o, res_we_o, carry_o, zero_o, neg_o;
   logic [DATA_W-1:0]         res_o, mem_wdata_o;
   logic [DATA_W-1:0]         mem_rdata_i = '0;
   logic [TGT_W-1:0]          res_tgt_o;
   logic [ADDR_W-1:0]         mem_addr_o;
   logic                      mem_rd_o, mem_wr_o;

   rmw_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX), .READ_LAT(1)) i_rmw_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .tgt_i(tgt_i),
      .addr_i(addr_i), .acc_i(acc_i), .idx_i(idx_i), .carry_i(carry_i),
      .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .res_we_o(res_we_o),
      .res_tgt_o(res_tgt_o), .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o),
      .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
      .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // bus memory seen by the design, and the model's own copy
   logic [7:0] mem [int];
   logic [7:0] exp_mem [int];

   task automatic poke(input int a, input int v);
      mem[a]     = 8'(v);
      exp_mem[a] = 8'(v);
   endtask

   always @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 8'h00;
      if (mem_wr_o) mem[int'(mem_addr_o)] = mem_wdata_o;
   end

   // behavioural reference: returns {carry, result}
   function automatic int ref_calc(input int op, input int v, input int c);
      int r, co;
      r = v; co = c;
      case (op)
         0: begin r = (v << 1) & 255;       co = (v >> 7) & 1; end
         1: begin r = v >> 1;               co = v & 1;        end
         2: begin r = ((v << 1) | c) & 255; co = (v >> 7) & 1; end
         3: begin r = (v >> 1) | (c << 7);  co = v & 1;        end
         4: begin r = (v + 1) & 255;        co = c;            end
         5: begin r = (v + 255) & 255;      co = c;            end
         default: ;
      endcase
      return (co << 8) | r;
   endfunction

   function automatic string op_tag(input int op);
      if (op < 2) return "R2";
      if (op < 4) return "R3";
      return "R4";
   endfunction

   // phase: 0 idle, 1 read strobe, 2 waiting for data, 3 write, 4 register result
   int m_phase = 0;
   int m_op, m_tgt, m_addr, m_val, m_cin;

   always @(posedge clk) begin
      if (!rst_n) m_phase = 0;
      else begin
         case (m_phase)
            0: if (start_i && op_i <= 3'd5 && int'(tgt_i) <= MEM_TGT) begin
                  m_op = op_i; m_tgt = tgt_i; m_addr = addr_i; m_cin = carry_i;
                  if (m_tgt == MEM_TGT) m_phase = 1;
                  else begin
                     m_val = (m_tgt == 0) ? int'(acc_i) :
                             (m_tgt == 1) ? int'(idx_i[7:0]) : int'(idx_i[15:8]);
                     m_phase = 4;
                  end
               end
            1: m_phase = 2;
            2: begin
                  m_val = exp_mem.exists(m_addr) ? int'(exp_mem[m_addr]) : 0;
                  m_phase = 3;
               end
            3: begin
                  exp_mem[m_addr] = 8'(ref_calc(m_op, m_val, m_cin));
                  m_phase = 0;
               end
            default: m_phase = 0;
         endcase
      end
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      int e;
      check("R7", "busy", int'(busy_o), int'(m_phase != 0));
      check("R6", "mem_rd", int'(mem_rd_o), int'(m_phase == 1));
      check("R6", "mem_wr", int'(mem_wr_o), int'(m_phase == 3));
      check("R1", "done", int'(done_o), int'(m_phase == 3 || m_phase == 4));
      check("R9", "res_we", int'(res_we_o), int'(m_phase == 4));
      if (m_phase == 1 || m_phase == 3) check("R6", "mem_addr", int'(mem_addr_o), m_addr);
      if (m_phase == 3 || m_phase == 4) begin
         e = ref_calc(m_op, m_val, m_cin);
         check(op_tag(m_op), "result", int'(res_o), e & 255);
         check(op_tag(m_op), "carry", int'(carry_o), (e >> 8) & 1);
         check("R5", "zero", int'(zero_o), int'((e & 255) == 0));
         check("R5", "neg", int'(neg_o), (e >> 7) & 1);
         if (m_phase == 3) check("R6", "wdata", int'(mem_wdata_o), e & 255);
         if (m_phase == 4) check("R1", "res_tgt", int'(res_tgt_o), m_tgt);
      end
   end

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_LIMIT) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
         summary();
         $finish;
      end
   end

   task automatic wait_idle;
      for (int n = 0; n < 20 && busy_o; n++) @(negedge clk);
   endtask

   task automatic issue(input int op, input int tgt, input int addr,
                        input int a, input int x, input int y, input int c);
      @(negedge clk);
      op_i = 3'(op); tgt_i = TGT_W'(tgt); addr_i = ADDR_W'(addr);
      acc_i = 8'(a); idx_i = {8'(y), 8'(x)}; carry_i = c[0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check("R7", "reset busy", int'(busy_o), 0);
      check("R7", "reset done", int'(done_o), 0);
      rst_n = 1'b1;

      // R2: shifts on the accumulator
      issue(0, 0, 0, 8'h81, 0, 0, 0);
      issue(1, 0, 0, 8'h01, 0, 0, 1);
      // R3: rotates with injected carry, on index registers
      issue(2, 1, 0, 0, 8'h80, 0, 1);
      issue(3, 2, 0, 0, 0, 8'h01, 1);
      issue(3, 0, 0, 8'h00, 0, 0, 0);
      // R4: wrap cases, carry kept both ways
      issue(5, 0, 0, 8'h80, 0, 0, 1);
      issue(5, 1, 0, 0, 8'h00, 0, 0);
      issue(4, 2, 0, 0, 0, 8'hFF, 1);

      // R6: memory targets across the 16-bit address range
      poke(16'hA1B2, 8'h05);
      poke(16'hFFFF, 8'h80);
      poke(16'h0000, 8'h01);
      issue(5, MEM_TGT, 16'hA1B2, 0, 0, 0, 0);
      issue(0, MEM_TGT, 16'hFFFF, 0, 0, 0, 0);
      issue(3, MEM_TGT, 16'h0000, 0, 0, 0, 1);
      issue(2, MEM_TGT, 16'hA1B2, 0, 0, 0, 1);

      // R7: a second request during a memory sequence is dropped
      poke(16'h1234, 8'h7F);
      @(negedge clk);
      op_i = 3'd4; tgt_i = TGT_W'(MEM_TGT); addr_i = 16'h1234; carry_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      op_i = 3'd0; tgt_i = 2'd0; acc_i = 8'h40;
      @(negedge clk);
      @(negedge clk);
      check("R7", "busy held through write", int'(busy_o), 1);
      start_i = 1'b0;
      @(negedge clk);
      check("R7", "request during busy dropped", int'(busy_o), 0);

      // R8: unused operation codes are dropped
      @(negedge clk);
      op_i = 3'd6; tgt_i = 2'd0; start_i = 1'b1;
      @(negedge clk);
      check("R8", "code 6 busy", int'(busy_o), 0);
      op_i = 3'd7; tgt_i = TGT_W'(MEM_TGT);
      @(negedge clk);
      check("R8", "code 7 busy", int'(busy_o), 0);
      check("R8", "code 7 mem_rd", int'(mem_rd_o), 0);
      start_i = 1'b0;

      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         int op, tgt, ad;
         op  = int'($urandom_range(0, 5));
         tgt = int'($urandom_range(0, 3));
         ad  = (i % 3 == 0) ? 16'hFFFF - (i & 7) : (i * 37) & 16'hFFFF;
         issue(op, tgt, ad, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 255)), int'($urandom_range(0, 1)));
      end

      // R6: memory content matches the model
      @(negedge clk);
      foreach (exp_mem[k]) begin
         check("R6", "memory byte", mem.exists(k) ? int'(mem[k]) : 0, int'(exp_mem[k]));
      end

      summary();
      $finish;
   end

endmodule